// File: doc/BRIEF.md
# Sub-word pan aligner for a display fetch stream

This block sits on the path from the frame-buffer fetch logic to the pixel unpacker. It takes a stream of 32-bit memory words and moves every word toward its most significant end by a programmable number of bits, from 0 to 31. The bits that leave the top of a word are replaced by the top bits of the word that follows it. The displayed image therefore pans left by part of a word. Pans of one whole word or more are made by moving the fetch start address, and that happens outside this block.

The bit offset and the colour-depth code are captured only when the frame-start strobe is seen. Changes made to them during a frame wait for the next frame. The strobe also empties the one-word lookahead stage, so the first output word of each frame is built only from words of that frame. A side output gives the pixel pan that the captured offset produces at the captured depth.

Top module: `pixpan_align`

## Requirements
- R1: In reset and after reset, `dout_valid` is 0, `din_ready` is 1 while no frame strobe is present, and `pan_pixels` is 0.
- R2: Each output word equals the upper 32 bits of the 64-bit value {held word, presented word} shifted left by the captured offset. The held word is the earlier of two consecutive accepted input words.
- R3: With a captured offset of 0, each output word equals the held input word unchanged.
- R4: `pan_bits` and `depth_code` are sampled only in a cycle with `frame_sof` high. Changes at any other time have no effect on `dout_data` or `pan_pixels` until the next strobe.
- R5: In a `frame_sof` cycle, `din_ready` and `dout_valid` are 0, and the lookahead stage is emptied. The first output word of a frame appears only when the second input word of that frame is presented.
- R6: While a word is held and `dout_ready` is 0, `din_ready` is 0, and the held word stays unchanged.
- R7: Accepted words are never dropped or reordered. A frame of N accepted words yields exactly N-1 output words, one for each consecutive pair, in order.
- R8: `pan_pixels` equals the captured offset divided by the pixel width. The depth codes are 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp and 4=12/16 bpp (16-bit storage). Codes 5 to 7 act as code 4.
- R9: `dout_valid` is 1 only when a word is held and `din_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_sof | input | 1 | Frame-start strobe, one cycle long |
| pan_bits | input | 5 | Left pan in bits, captured at frame start |
| depth_code | input | 3 | Colour-depth code, captured at frame start |
| din_valid | input | 1 | Input word valid |
| din_data | input | 32 | Input memory word |
| din_ready | output | 1 | Input word accepted when high together with din_valid |
| dout_valid | output | 1 | Output word valid |
| dout_data | output | 32 | Realigned output word |
| dout_ready | output | 1 | Downstream ready |
| pan_pixels | output | 5 | Pixel pan implied by the captured offset and depth |

(`dout_ready` is an input; see the table correction below.)

| Port | Direction | Width | Description |
|---|---|---|---|
| dout_ready | input | 1 | Downstream ready |

## Verification
The checker tests these properties on every cycle: the strobe gating of both handshakes, emptying of the lookahead, stability of the held word and of the captured offset under stall, output valid only with a held word and a presented word, pass-through at offset zero, and the bound on the pixel pan. Only the bench scenarios can show that the stitched data is correct for every offset, that no word is lost or reordered across irregular valid and ready patterns, that changes to the offset during a frame stay invisible, and that the pixel pan is right for every depth code.

// File: rtl/pixpan_pkg.sv
package pixpan_pkg;
  localparam int unsigned DEPTH_W = 3;

  // log2 of storage bits per pixel for a depth code; codes above 4 act as 16-bit storage
  function automatic logic [2:0] depth_log2(input logic [DEPTH_W-1:0] code);
    logic [2:0] r;
    if (code > 3'd4) r = 3'd4;
    else             r = code;
    return r;
  endfunction
endpackage

// File: rtl/pixpan_cfg_latch.sv
module pixpan_cfg_latch #(
  parameter int unsigned OFS_W = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sof,
  input  logic [OFS_W-1:0]                 ofs_in,
  input  logic [pixpan_pkg::DEPTH_W-1:0]   depth_in,
  output logic [OFS_W-1:0]                 ofs_q,
  output logic [OFS_W-1:0]                 pix_pan
);
  logic [pixpan_pkg::DEPTH_W-1:0] depth_q;
  logic [OFS_W-1:0]               ofs_d;
  logic [pixpan_pkg::DEPTH_W-1:0] depth_d;
  logic                           cap_en;

  always_comb begin
    cap_en  = sof;
    ofs_d   = ofs_in;
    depth_d = depth_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      depth_q <= '0;
    end else if (cap_en) begin
      ofs_q   <= ofs_d;
      depth_q <= depth_d;
    end
  end

  assign pix_pan = ofs_q >> pixpan_pkg::depth_log2(depth_q);
endmodule

// File: rtl/pixpan_lookahead.sv
module pixpan_lookahead #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] held_q,
  output logic              held_vld
);
  logic              take;
  logic              vld_d;
  logic [WORD_W-1:0] word_d;
  logic              word_en;

  always_comb begin
    in_ready  = !flush && (!held_vld || out_ready);
    out_valid = !flush && held_vld && in_valid;
    take      = in_valid && in_ready;
    word_en   = take;
    word_d    = in_data;
    if (flush)     vld_d = 1'b0;
    else if (take) vld_d = 1'b1;
    else           vld_d = held_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_vld <= 1'b0;
    else        held_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (word_en) held_q <= word_d;
  end
endmodule

// File: rtl/pixpan_stitch.sv
module pixpan_stitch #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SH_W   = 5
) (
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [SH_W-1:0]   shift,
  output logic [WORD_W-1:0] result
);
  localparam int unsigned CAT_W = 2 * WORD_W;

  logic [CAT_W-1:0] stage [0:SH_W];

  assign stage[0] = {hi_word, lo_word};

  // logarithmic shifter: stage k moves by 2**k when its shift bit is set
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign stage[k+1] = shift[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign result = stage[SH_W][CAT_W-1:WORD_W];
endmodule

// File: rtl/pixpan_align.sv
module pixpan_align #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   frame_sof,
  input  logic [$clog2(WORD_W)-1:0]              pan_bits,
  input  logic [pixpan_pkg::DEPTH_W-1:0]         depth_code,
  input  logic                                   din_valid,
  input  logic [WORD_W-1:0]                      din_data,
  output logic                                   din_ready,
  output logic                                   dout_valid,
  output logic [WORD_W-1:0]                      dout_data,
  input  logic                                   dout_ready,
  output logic [$clog2(WORD_W)-1:0]              pan_pixels
);
  localparam int unsigned OFS_W = $clog2(WORD_W);

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic [OFS_W-1:0]  ofs_q;
  logic [WORD_W-1:0] held_q;
  logic              held_vld;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pixpan_cfg_latch #(.OFS_W(OFS_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sof      (frame_sof),
    .ofs_in   (pan_bits),
    .depth_in (depth_code),
    .ofs_q    (ofs_q),
    .pix_pan  (pan_pixels)
  );

  pixpan_lookahead #(.WORD_W(WORD_W)) u_look (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (frame_sof),
    .in_valid  (din_valid),
    .in_data   (din_data),
    .in_ready  (din_ready),
    .out_ready (dout_ready),
    .out_valid (dout_valid),
    .held_q    (held_q),
    .held_vld  (held_vld)
  );

  pixpan_stitch #(.WORD_W(WORD_W), .SH_W(OFS_W)) u_stitch (
    .hi_word (held_q),
    .lo_word (din_data),
    .shift   (ofs_q),
    .result  (dout_data)
  );
endmodule

// File: rtl/pixpan_align_chk.sv
module pixpan_align_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned OFS_W  = 5
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              frame_sof,
  input logic              din_valid,
  input logic              din_ready,
  input logic              dout_valid,
  input logic              dout_ready,
  input logic [WORD_W-1:0] dout_data,
  input logic [OFS_W-1:0]  pan_pixels,
  input logic [OFS_W-1:0]  ofs_q,
  input logic [WORD_W-1:0] held_q,
  input logic              held_vld
);
  // R5
  sof_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_sof |-> (!din_ready && !dout_valid));

  // R5
  sof_flush_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_sof |=> !held_vld);

  // R6
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (held_vld && !dout_ready) |-> !din_ready);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (held_vld && !dout_ready && !frame_sof) |=> (held_vld && $stable(held_q)));

  // R4
  ofs_freeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !frame_sof |=> $stable(ofs_q));

  // R9
  out_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dout_valid |-> (held_vld && din_valid));

  // R3
  zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dout_valid && ofs_q == '0) |-> (dout_data == held_q));

  // R8
  pan_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pan_pixels <= ofs_q);
endmodule

bind pixpan_align pixpan_align_chk #(.WORD_W(WORD_W), .OFS_W($clog2(WORD_W))) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .frame_sof  (frame_sof),
  .din_valid  (din_valid),
  .din_ready  (din_ready),
  .dout_valid (dout_valid),
  .dout_ready (dout_ready),
  .dout_data  (dout_data),
  .pan_pixels (pan_pixels),
  .ofs_q      (ofs_q),
  .held_q     (held_q),
  .held_vld   (held_vld)
);

// File: tb/pixpan_align_bench.sv
module pixpan_align_bench;
  localparam int NW = 6;

  logic        clk;
  logic        rst_n;
  logic        frame_sof;
  logic [4:0]  pan_bits;
  logic [2:0]  depth_code;
  logic        din_valid;
  logic [31:0] din_data;
  logic        din_ready;
  logic        dout_valid;
  logic [31:0] dout_data;
  logic        dout_ready;
  logic [4:0]  pan_pixels;

  int checks;
  int failures;
  bit done;

  pixpan_align u_pixpan_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sof  (frame_sof),
    .pan_bits   (pan_bits),
    .depth_code (depth_code),
    .din_valid  (din_valid),
    .din_data   (din_data),
    .din_ready  (din_ready),
    .dout_valid (dout_valid),
    .dout_data  (dout_data),
    .dout_ready (dout_ready),
    .pan_pixels (pan_pixels)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] a, input logic [31:0] b, input int s);
    logic [31:0] lo;
    lo = (s == 0) ? 32'h0 : (b >> (32 - s));
    return (a << s) | lo;
  endfunction

  function automatic int pix_width(input int code);
    int w;
    case (code)
      0: w = 1;
      1: w = 2;
      2: w = 4;
      3: w = 8;
      default: w = 16;
    endcase
    return w;
  endfunction

  task automatic run_frame(input int f, input int ofs, input int dcode);
    logic [31:0] w [0:NW-1];
    int idx;
    int outcnt;
    int cyc;
    for (int k = 0; k < NW; k++) w[k] = (f + 1) * 32'h9E3779B1 ^ (k + 3) * 32'h7F4A7C15;
    // frame strobe cycle, with a word offered that must not be taken
    @(negedge clk);
    frame_sof  = 1'b1;
    pan_bits   = ofs[4:0];
    depth_code = dcode[2:0];
    din_valid  = 1'b1;
    din_data   = 32'hDEAD_BEEF;
    dout_ready = 1'b1;
    #1;
    check(!din_ready, "R5 ready in strobe", {31'h0, din_ready}, 32'h0);
    check(!dout_valid, "R5 valid in strobe", {31'h0, dout_valid}, 32'h0);
    @(posedge clk);
    idx = 0;
    outcnt = 0;
    cyc = 0;
    while (idx < NW && cyc < 100) begin
      @(negedge clk);
      frame_sof  = 1'b0;
      // later changes must be ignored until the next strobe (R4)
      if (cyc == 2) begin
        pan_bits   = ~ofs[4:0];
        depth_code = dcode[2:0] + 3'd1;
      end
      din_valid  = ((cyc * 3 + f) % 7) != 0;
      din_data   = w[idx];
      dout_ready = ((cyc * 7 + f) % 5) != 0;
      #1;
      // R9 and R5: output only with a held word of this frame and a presented word
      check(dout_valid == (idx >= 1 && din_valid), "R9 dout_valid",
            {31'h0, dout_valid}, {31'h0, (idx >= 1 && din_valid)});
      // R6: no acceptance while held word is stalled
      check(din_ready == (idx == 0 || dout_ready), "R6 din_ready",
            {31'h0, din_ready}, {31'h0, (idx == 0 || dout_ready)});
      if (dout_valid && dout_ready) begin
        // R2 stitched data, R3 pass-through at zero, R4 latched offset
        check(dout_data == expect_word(w[idx-1], w[idx], ofs),
              (ofs == 0) ? "R3 pass-through" : "R2 stitch", dout_data, expect_word(w[idx-1], w[idx], ofs));
        check(outcnt == idx - 1, "R7 order", outcnt, idx - 1);
        outcnt++;
      end
      if (din_valid && din_ready) idx++;
      cyc++;
      @(posedge clk);
    end
    @(negedge clk);
    din_valid = 1'b0;
    #1;
    // R7: N accepted words give N-1 outputs
    check(outcnt == NW - 1, "R7 count", outcnt, NW - 1);
    // R8 pixel pan from captured values; R4 mid-frame change ignored
    check(pan_pixels == ofs / pix_width(dcode), "R8 pan_pixels", {27'h0, pan_pixels}, ofs / pix_width(dcode));
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    frame_sof = 1'b0;
    pan_bits = 5'd0;
    depth_code = 3'd0;
    din_valid = 1'b0;
    din_data = 32'h0;
    dout_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!dout_valid, "R1 reset valid", {31'h0, dout_valid}, 32'h0);
    check(pan_pixels == 5'd0, "R1 reset pan", {27'h0, pan_pixels}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(din_ready, "R1 ready after reset", {31'h0, din_ready}, 32'h1);
    check(!dout_valid, "R1 valid after reset", {31'h0, dout_valid}, 32'h0);
    for (int d = 0; d < 8; d++) begin
      for (int o = 0; o < 32; o++) run_frame(d * 32 + o, o, d);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule